// File: doc/BRIEF.md
# Ping-Pong Transmit Buffer Fetch Engine

This block feeds one serial transmit channel with bytes read from external memory. The host prepares two buffer descriptors, A and B. Each descriptor holds a start address, a byte count and two status flags: an ownership flag and an end-of-frame flag. Setting the ownership flag hands a descriptor to the engine. The engine then reads the buffer one byte at a time through a simple request/response memory port and presents each byte on a ready/valid stream toward the serializer.

The engine alternates between the two descriptors. A next-buffer flag tells the host which descriptor will be taken next. The flag toggles each time a buffer is started. When a buffer without the end-of-frame flag finishes, the engine moves straight on to the other buffer if it owns that one. When a buffer is fully sent, the engine hands it back to the host by clearing its ownership flag, and it raises a level interrupt.

An append mode lets the host keep growing the active buffer's byte count while sending continues. In this mode the engine waits at the current count rather than releasing the buffer. It finishes only after the host pulses an append-complete command.

Top module: `txpp_dma`

## Requirements
- R1: After reset, `busy`, `next_buf`, `buf_own`, `eob_irq`, `mem_req` and `tx_valid` are all 0.
- R2: Host writes use these encodings. `host_sel` 0 selects buffer A and 1 selects buffer B. `host_field` 0 writes the start address from `host_wdata`. Field 1 writes the byte count from `host_wdata[15:0]`. Field 2 writes the status: bit 0 is the ownership flag and bit 1 is the end-of-frame flag.
- R3: When the engine is idle and the buffer named by `next_buf` is owned, the engine starts that buffer. On the following cycle `busy` is 1, `next_buf` has toggled, and `cur_addr` holds the buffer's start address.
- R4: Only one memory read is outstanding at a time. `mem_req` stays high with `mem_addr` equal to `cur_addr` until `mem_rvalid` arrives, and then `cur_addr` advances by one. The byte is held on `tx_data` with `tx_valid` high until `tx_ready` is seen. No new request is made while a byte waits on the stream.
- R5: A buffer with start address S and count N delivers exactly N bytes: the memory contents at S, S+1, …, S+N-1, in that order. Afterwards `cur_addr` equals S+N.
- R6: After the last byte of a buffer is accepted, the engine clears that buffer's ownership flag, sets `eob_irq`, and returns to idle with `busy` low.
- R7: When a finished buffer lacks the end-of-frame flag and the other buffer is owned, the engine continues into the other buffer without host action.
- R8: With append mode off, the final byte of a buffer that has the end-of-frame flag carries `tx_last` = 1. All other bytes carry `tx_last` = 0.
- R9: If the buffer named by `next_buf` is not owned, the engine stays idle with `busy` = 0 and `mem_req` = 0. This holds even when the other buffer is owned.
- R10: A buffer with a byte count of zero is released at once. Its ownership flag clears and `eob_irq` sets, and no memory read and no stream byte occur.
- R11: With `append_en` high, reaching the byte count does not release the buffer. A raised count is honoured and sending continues. The buffer is released only after an `append_done` pulse, once every counted byte has been sent.
- R12: `eob_irq` stays high until a cycle with `irq_clr` = 1 clears it. If a release happens in the same cycle as the clear, the interrupt stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host descriptor write strobe |
| host_sel | input | 1 | Descriptor select, 0 = A, 1 = B |
| host_field | input | 2 | Field select: 0 address, 1 count, 2 status |
| host_wdata | input | 32 | Host write data |
| append_en | input | 1 | Append mode enable |
| append_done | input | 1 | Append-complete command pulse |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt |
| mem_req | output | 1 | Memory byte read request |
| mem_addr | output | 32 | Memory read address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 8 | Memory read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream byte accepted |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of frame |
| busy | output | 1 | Engine is working on a buffer |
| next_buf | output | 1 | Descriptor the engine takes next, 0 = A, 1 = B |
| cur_addr | output | 32 | Address of the next byte to fetch |
| buf_own | output | 2 | Ownership flags, bit 0 = A, bit 1 = B |
| eob_irq | output | 1 | End-of-buffer interrupt level |

## Verification
Some properties can be checked on every cycle:
- The engine never requests memory while idle.
- Each buffer start flips the next-buffer flag and raises busy.
- Each completed read steps the current address by one.
- A stalled stream byte holds steady.
- Every release raises the interrupt, and the interrupt obeys its hold and clear rules.

Other behaviour needs the bench's scenarios:
- The byte order and count for a buffer.
- The placement of the last marker.
- The handover of ownership.
- Chaining into the other buffer.
- The wait on an unowned next buffer.
- The zero-count release.
- An append sequence that raises the count mid-flight.

// File: rtl/txpp_pkg.sv
package txpp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_SEND
  } eng_state_e;

  localparam logic [1:0] FLD_ADDR = 2'd0;
  localparam logic [1:0] FLD_CNT  = 2'd1;
  localparam logic [1:0] FLD_STAT = 2'd2;

  localparam int OWN_BIT = 0;
  localparam int EOF_BIT = 1;
endpackage

// File: rtl/txpp_desc.sv
module txpp_desc
  import txpp_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_wr,
  input  logic                   host_sel,
  input  logic [1:0]             host_field,
  input  logic [AW-1:0]          host_wdata,
  input  logic                   rel_evt,
  input  logic                   rel_sel,
  output logic [1:0][AW-1:0]     d_addr,
  output logic [1:0][CW-1:0]     d_cnt,
  output logic [1:0]             d_own,
  output logic [1:0]             d_eof
);
  localparam int NBUF = 2;

  for (genvar i = 0; i < NBUF; i++) begin : g_buf
    logic          hit;
    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt_q;
    logic          own_q;
    logic          eof_q;

    assign hit = host_wr && (host_sel == 1'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q <= '0;
        cnt_q  <= '0;
        own_q  <= 1'b0;
        eof_q  <= 1'b0;
      end else begin
        if (hit && host_field == FLD_ADDR) addr_q <= host_wdata;
        if (hit && host_field == FLD_CNT)  cnt_q  <= host_wdata[CW-1:0];
        if (hit && host_field == FLD_STAT) begin
          own_q <= host_wdata[OWN_BIT];
          eof_q <= host_wdata[EOF_BIT];
        end
        // engine release has priority over a host status write
        if (rel_evt && rel_sel == 1'(i)) own_q <= 1'b0;
      end
    end

    assign d_addr[i] = addr_q;
    assign d_cnt[i]  = cnt_q;
    assign d_own[i]  = own_q;
    assign d_eof[i]  = eof_q;
  end
endmodule

// File: rtl/txpp_engine.sv
module txpp_engine
  import txpp_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0][AW-1:0] d_addr,
  input  logic [1:0][CW-1:0] d_cnt,
  input  logic [1:0]         d_own,
  input  logic [1:0]         d_eof,
  input  logic               append_en,
  input  logic               append_done,
  output logic               mem_req,
  input  logic               mem_rvalid,
  input  logic [DW-1:0]      mem_rdata,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [DW-1:0]      tx_data,
  output logic               tx_last,
  output logic               busy,
  output logic               next_buf,
  output logic [AW-1:0]      cur_addr,
  output logic               start_evt,
  output logic               release_evt,
  output logic               release_sel
);
  eng_state_e    state;
  logic          act;
  logic [CW-1:0] sent;
  logic          app_cmp;
  logic          count_done;

  function automatic logic [AW-1:0] addr_step(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic cnt_reached(input logic [CW-1:0] n_sent,
                                       input logic [CW-1:0] n_total);
    return n_sent >= n_total;
  endfunction

  function automatic logic is_final(input logic [CW-1:0] n_sent,
                                    input logic [CW-1:0] n_total);
    return ({1'b0, n_sent} + (CW+1)'(1)) >= {1'b0, n_total};
  endfunction

  assign count_done  = cnt_reached(sent, d_cnt[act]);
  assign start_evt   = (state == ST_IDLE) && d_own[next_buf];
  assign release_evt = (state == ST_CHECK) && count_done && (!append_en || app_cmp);
  assign release_sel = act;
  assign mem_req     = (state == ST_FETCH);
  assign tx_valid    = (state == ST_SEND);
  assign busy        = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      act      <= 1'b0;
      next_buf <= 1'b0;
      cur_addr <= '0;
      sent     <= '0;
      app_cmp  <= 1'b0;
      tx_data  <= '0;
      tx_last  <= 1'b0;
    end else begin
      if (append_done && state != ST_IDLE) app_cmp <= 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (start_evt) begin
            act      <= next_buf;
            next_buf <= ~next_buf;
            cur_addr <= d_addr[next_buf];
            sent     <= '0;
            app_cmp  <= 1'b0;
            state    <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (release_evt) begin
            app_cmp <= 1'b0;
            state   <= ST_IDLE;
          end else if (!count_done) begin
            state <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_rvalid) begin
            tx_data  <= mem_rdata;
            tx_last  <= d_eof[act] && !append_en && is_final(sent, d_cnt[act]);
            cur_addr <= addr_step(cur_addr);
            sent     <= sent + CW'(1);
            state    <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (tx_ready) state <= ST_CHECK;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txpp_dma.sv
module txpp_dma
  import txpp_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_sel,
  input  logic [1:0]    host_field,
  input  logic [AW-1:0] host_wdata,
  input  logic          append_en,
  input  logic          append_done,
  input  logic          irq_clr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  output logic          tx_last,
  output logic          busy,
  output logic          next_buf,
  output logic [AW-1:0] cur_addr,
  output logic [1:0]    buf_own,
  output logic          eob_irq
);
  logic [1:0][AW-1:0] d_addr;
  logic [1:0][CW-1:0] d_cnt;
  logic [1:0]         d_own;
  logic [1:0]         d_eof;
  logic               start_evt;
  logic               release_evt;
  logic               release_sel;

  txpp_desc #(.AW(AW), .CW(CW)) u_desc (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_sel   (host_sel),
    .host_field (host_field),
    .host_wdata (host_wdata),
    .rel_evt    (release_evt),
    .rel_sel    (release_sel),
    .d_addr     (d_addr),
    .d_cnt      (d_cnt),
    .d_own      (d_own),
    .d_eof      (d_eof)
  );

  txpp_engine #(.AW(AW), .CW(CW), .DW(DW)) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .d_addr      (d_addr),
    .d_cnt       (d_cnt),
    .d_own       (d_own),
    .d_eof       (d_eof),
    .append_en   (append_en),
    .append_done (append_done),
    .mem_req     (mem_req),
    .mem_rvalid  (mem_rvalid),
    .mem_rdata   (mem_rdata),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_data     (tx_data),
    .tx_last     (tx_last),
    .busy        (busy),
    .next_buf    (next_buf),
    .cur_addr    (cur_addr),
    .start_evt   (start_evt),
    .release_evt (release_evt),
    .release_sel (release_sel)
  );

  assign mem_addr = cur_addr;
  assign buf_own  = d_own;

  always_ff @(posedge clk) begin
    if (!rst_n)           eob_irq <= 1'b0;
    else if (release_evt) eob_irq <= 1'b1;
    else if (irq_clr)     eob_irq <= 1'b0;
  end
endmodule

// File: rtl/txpp_chk.sv
module txpp_chk #(
  parameter int AW = 32,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          next_buf,
  input logic          mem_req,
  input logic          mem_rvalid,
  input logic [AW-1:0] cur_addr,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [DW-1:0] tx_data,
  input logic          tx_last,
  input logic          eob_irq,
  input logic          irq_clr,
  input logic          start_evt,
  input logic          release_evt
);
  AST_IDLE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R9

  AST_START_FLIPS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (next_buf != $past(next_buf)) && busy); // R3

  AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rvalid) |=> (cur_addr == $past(cur_addr) + AW'(1))); // R4

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R4

  AST_RELEASE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> eob_irq); // R6

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (eob_irq && !irq_clr) |=> eob_irq); // R12

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (eob_irq && irq_clr && !release_evt) |=> !eob_irq); // R12
endmodule

bind txpp_dma txpp_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .next_buf    (next_buf),
  .mem_req     (mem_req),
  .mem_rvalid  (mem_rvalid),
  .cur_addr    (cur_addr),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .tx_data     (tx_data),
  .tx_last     (tx_last),
  .eob_irq     (eob_irq),
  .irq_clr     (irq_clr),
  .start_evt   (start_evt),
  .release_evt (release_evt)
);

// File: tb/txpp_dma_tb.sv
module txpp_dma_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_sel = 1'b0;
  logic [1:0]  host_field = 2'd0;
  logic [31:0] host_wdata = '0;
  logic        append_en = 1'b0;
  logic        append_done = 1'b0;
  logic        irq_clr = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        tx_valid;
  logic        tx_ready;
  logic [7:0]  tx_data;
  logic        tx_last;
  logic        busy;
  logic        next_buf;
  logic [31:0] cur_addr;
  logic [1:0]  buf_own;
  logic        eob_irq;

  always #5 clk = ~clk;

  txpp_dma u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_field(host_field), .host_wdata(host_wdata), .append_en(append_en),
    .append_done(append_done), .irq_clr(irq_clr), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .busy(busy), .next_buf(next_buf), .cur_addr(cur_addr),
    .buf_own(buf_own), .eob_irq(eob_irq)
  );

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // memory model: one byte, one cycle after a request
  always @(posedge clk) begin
    mem_rvalid <= mem_req && !mem_rvalid;
    mem_rdata  <= pat(mem_addr);
  end

  logic [7:0] tick = '0;
  logic       slow = 1'b0;
  always @(posedge clk) tick <= tick + 8'd1;
  assign tx_ready = !slow || (tick[1:0] != 2'b11);

  logic [7:0] cap_data [0:255];
  logic       cap_last [0:255];
  int         cap_n = 0;
  int         rd_n = 0;
  always @(posedge clk) begin
    if (tx_valid && tx_ready) begin
      cap_data[cap_n] <= tx_data;
      cap_last[cap_n] <= tx_last;
      cap_n <= cap_n + 1;
    end
    if (mem_req && mem_rvalid) rd_n <= rd_n + 1;
  end

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic exp_nb = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hwrite(input logic sel, input logic [1:0] fld, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_field = fld; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic wait_quiet(input string req);
    int k;
    k = 0;
    @(negedge clk);
    while ((buf_own != 2'b00 || busy) && k < 3000) begin
      @(negedge clk);
      k++;
    end
    check(k < 3000, {req, " completion timeout"}, k, 0);
  endtask

  // checks the bytes of one buffer within the captured stream
  task automatic check_bytes(input int base, input logic [31:0] a, input int n,
                             input bit last_exp, input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      if (cap_data[base+i] !== pat(a + 32'(i))) bad++;
      if (cap_last[base+i] !== (last_exp && i == n - 1)) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  typedef struct packed {
    logic [31:0] a;
    logic [15:0] n;
    logic        eof;
    logic        slw;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VEC [0:NV-1] = '{
    '{32'h0000_1000, 16'd1,  1'b1, 1'b0},
    '{32'h0000_20FE, 16'd4,  1'b1, 1'b1},
    '{32'h0000_3010, 16'd7,  1'b0, 1'b0},
    '{32'h0001_FFFF, 16'd3,  1'b1, 1'b1},
    '{32'h0000_0040, 16'd16, 1'b1, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    int rd0;
    logic sel;
    cycles(5);
    rst_n = 1'b1;
    cycles(1);
    // R1 reset state
    check({busy, next_buf, buf_own, eob_irq, mem_req, tx_valid} == 7'd0, "R1 reset outputs",
          {busy, next_buf, buf_own, eob_irq, mem_req, tx_valid}, 0);

    // vector table: single buffers, alternating A/B (R2 R3 R4 R5 R6 R8)
    for (int v = 0; v < NV; v++) begin
      base = cap_n;
      sel  = exp_nb;
      slow = VEC[v].slw;
      hwrite(sel, 2'd0, VEC[v].a);
      hwrite(sel, 2'd1, {16'd0, VEC[v].n});
      hwrite(sel, 2'd2, {30'd0, VEC[v].eof, 1'b1});
      wait_quiet("R2");
      check(cap_n - base == int'(VEC[v].n), "R5 byte count", cap_n - base, VEC[v].n);
      check_bytes(base, VEC[v].a, int'(VEC[v].n), VEC[v].eof, "R5/R8 data and last");
      check(cur_addr == VEC[v].a + 32'(VEC[v].n), "R4 cur_addr after buffer",
            cur_addr, VEC[v].a + 32'(VEC[v].n));
      check(next_buf == ~sel, "R3 next_buf toggled", next_buf, ~sel);
      check(eob_irq && !buf_own[sel] && !busy, "R6 release", {eob_irq, buf_own, busy}, 4'b1000);
      clear_irq();
      exp_nb = ~sel;
    end
    slow = 1'b0;

    // R9: next is B, only A owned -> idle
    check(exp_nb == 1'b1 && next_buf == 1'b1, "R9 precondition next=B", next_buf, 1);
    rd0 = rd_n;
    hwrite(1'b0, 2'd0, 32'h0000_5000);
    hwrite(1'b0, 2'd1, 32'd2);
    hwrite(1'b0, 2'd2, 32'd3);
    cycles(20);
    check(!busy && rd_n == rd0 && buf_own == 2'b01 && !mem_req, "R9 idle on unowned next",
          {busy, buf_own}, 3'b001);

    // R7: B without eof chains into A
    base = cap_n;
    hwrite(1'b1, 2'd0, 32'h0000_6000);
    hwrite(1'b1, 2'd1, 32'd3);
    hwrite(1'b1, 2'd2, 32'd1);
    wait_quiet("R7");
    check(cap_n - base == 5, "R7 chained byte count", cap_n - base, 5);
    check_bytes(base, 32'h0000_6000, 3, 1'b0, "R7 chained B bytes");
    check_bytes(base + 3, 32'h0000_5000, 2, 1'b1, "R7/R8 chained A bytes");
    check(next_buf == 1'b1 && eob_irq, "R7 next_buf after two starts", next_buf, 1);
    clear_irq();
    check(!eob_irq, "R12 cleared by irq_clr", eob_irq, 0);

    // R10: zero count on B
    base = cap_n;
    rd0 = rd_n;
    hwrite(1'b1, 2'd1, 32'd0);
    hwrite(1'b1, 2'd2, 32'd3);
    cycles(10);
    check(eob_irq && buf_own == 2'b00 && rd_n == rd0 && cap_n == base && !busy,
          "R10 zero-count release", {eob_irq, buf_own, busy}, 4'b1000);
    check(next_buf == 1'b0, "R10 next_buf toggled", next_buf, 0);
    cycles(10);
    check(eob_irq, "R12 irq held without clear", eob_irq, 1);
    clear_irq();
    check(!eob_irq, "R12 irq cleared", eob_irq, 0);

    // R11: append mode on A
    append_en = 1'b1;
    base = cap_n;
    hwrite(1'b0, 2'd0, 32'h0000_7000);
    hwrite(1'b0, 2'd1, 32'd2);
    hwrite(1'b0, 2'd2, 32'd1);
    cycles(30);
    check(cap_n - base == 2 && busy && buf_own[0] && !eob_irq, "R11 waits at count",
          {busy, buf_own, eob_irq}, 4'b1010);
    hwrite(1'b0, 2'd1, 32'd5);
    cycles(30);
    check(cap_n - base == 5 && busy && buf_own[0], "R11 raised count honoured", cap_n - base, 5);
    @(negedge clk); append_done = 1'b1;
    @(negedge clk); append_done = 1'b0;
    cycles(5);
    check(eob_irq && !buf_own[0] && !busy && cur_addr == 32'h0000_7005, "R11 release after done",
          cur_addr, 32'h0000_7005);
    check_bytes(base, 32'h0000_7000, 5, 1'b0, "R11 append bytes");
    append_en = 1'b0;
    clear_irq();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule